// File: doc/BRIEF.md
# Synchronous SAR Conversion Sequencer

This block is the digital controller of a 6-bit successive-approximation converter. Its clock runs at eight times the conversion rate, so each conversion occupies exactly eight clock cycles. A one-hot ring register steps through eight phases in a fixed order. The first phase samples the input. The next six phases each settle one bit of a binary search, from the most significant bit to the least. The last phase clears the comparator's input memory, so that one sample has no effect on the next.

A second row of registers, one per bit, drives the switches of the binary-weighted capacitor DAC. In each bit phase the block presents a trial 1 on that bit. The single-bit comparator decision then decides whether the trial bit is kept. The block also drives the sample/hold control and a comparator reset strobe. It latches the finished 6-bit code and marks it with a done pulse one cycle long. The analog parts (the DAC, the comparator and the sampler) sit outside the block.

Top module: `sar_seq_top`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, the block holds the sample phase (`sampleHold`=1), `dacSwitch`=0, `resultCode`=0, `done`=0 and `compReset`=0.
- R2: The phases repeat with a period of exactly 8 clock cycles. The order is one sample cycle, then six bit cycles, then one reset cycle. Consecutive `done` pulses are therefore exactly 8 cycles apart.
- R3: In the bit phase for bit b (phase 1 handles bit 5, phase 6 handles bit 0), `dacSwitch[b]` is 1 as the trial value. Bits above b show their decided values, and bits below b are 0. In phase 1 this gives `dacSwitch`=6'b100000.
- R4: At the end of the bit phase for bit b, the decided bit b becomes the value of `compIn`. `compIn`=1 means the sampled input is at or above the level of the current DAC code.
- R5: In the sample phase, `sampleHold`=1 and `dacSwitch`=0. In every other phase, `sampleHold`=0.
- R6: `compReset` is 1 only in phase 7, the cycle that follows the last bit decision. The next cycle is a sample phase.
- R7: `resultCode` is updated at the end of the last bit phase and holds the complete code while `done`=1. It then stays unchanged until the next phase 7.
- R8: For any input level from 0 to 63 under an ideal comparator, `resultCode` equals that level.
- R9: Raising `rst` in the middle of a conversion returns the block to the sample phase on the next clock edge, with `dacSwitch` and `resultCode` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock, eight times the conversion rate |
| rst | input | 1 | Synchronous active-high reset |
| compIn | input | 1 | Comparator decision: 1 when the input is at or above the DAC level |
| sampleHold | output | 1 | Sample/hold control, high in the sample phase |
| compReset | output | 1 | Comparator input-memory clear strobe |
| dacSwitch | output | 6 | DAC capacitor switch drive, trial and decided bits |
| resultCode | output | 6 | Latched conversion result |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench drives the extreme levels 0 and 63, the codes on either side of mid-scale, and alternating bit patterns. A decision register with an off-by-one error, or an inverted keep/clear rule, would show a wrong code at exactly these boundaries. The bench checks that the first trial code is 100000 and that the DAC drive is zero while sampling. A design that failed to clear the previous conversion would carry stale bits into the trials. The spacing between done pulses is measured, so a ring with the wrong length or a broken wrap shows up as a period other than eight. A reset raised in mid-conversion must drop straight back to sampling, with the result cleared.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned RES    = 6;
  localparam int unsigned PHASES = RES + 2;

  typedef struct packed {
    logic           sampling;
    logic           clearing;
    logic           lastBit;
    logic [RES-1:0] bitStrobe;
  } seqStrobes_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output seqStrobes_t strobes
);
  logic [PHASES-1:0] ring;

  always_ff @(posedge clk) begin
    if (rst) ring <= {{(PHASES-1){1'b0}}, 1'b1};
    else     ring <= {ring[PHASES-2:0], ring[PHASES-1]};
  end

  assign strobes.sampling = ring[0];
  assign strobes.clearing = ring[PHASES-1];
  assign strobes.lastBit  = ring[RES];

  // bit RES-1 is decided in phase 1, bit 0 in phase RES
  for (genvar i = 0; i < RES; i++) begin : g_bitMap
    assign strobes.bitStrobe[i] = ring[RES-i];
  end
endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  seqStrobes_t    strobes,
  input  logic           compIn,
  output logic [RES-1:0] dacSwitch,
  output logic [RES-1:0] resultCode
);
  logic [RES-1:0] decided;
  logic [RES-1:0] nextDecided;

  assign nextDecided = (decided & ~strobes.bitStrobe) |
                       (strobes.bitStrobe & {RES{compIn}});
  assign dacSwitch   = decided | strobes.bitStrobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      decided    <= '0;
      resultCode <= '0;
    end else begin
      if (strobes.sampling || strobes.clearing) decided <= '0;
      else                                      decided <= nextDecided;
      if (strobes.lastBit) resultCode <= nextDecided;
    end
  end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           compIn,
  output logic           sampleHold,
  output logic           compReset,
  output logic [RES-1:0] dacSwitch,
  output logic [RES-1:0] resultCode,
  output logic           done
);
  seqStrobes_t strobes;

  sar_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes)
  );

  sar_seq_dp u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .compIn     (compIn),
    .dacSwitch  (dacSwitch),
    .resultCode (resultCode)
  );

  assign sampleHold = strobes.sampling;
  assign compReset  = strobes.clearing;
  assign done       = strobes.clearing;
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker
  import sar_seq_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           sampleHold,
  input logic           compReset,
  input logic [RES-1:0] dacSwitch,
  input logic [RES-1:0] resultCode,
  input logic           done
);
  logic [$clog2(PHASES)-1:0] phaseCnt;

  always_ff @(posedge clk) begin
    if (rst) phaseCnt <= '0;
    else     phaseCnt <= phaseCnt + 1'b1;
  end

  // R2: done appears only at the last phase of an eight-cycle frame
  a_r2_done_period: assert property (@(posedge clk) disable iff (rst)
    done |-> (phaseCnt == PHASES-1));

  // R5: DAC drive is zero while sampling
  a_r5_dac_zero_sample: assert property (@(posedge clk) disable iff (rst)
    sampleHold |-> (dacSwitch == '0));

  // R3: first trial after sampling is the MSB alone
  a_r3_msb_trial: assert property (@(posedge clk) disable iff (rst)
    sampleHold |=> (dacSwitch == {1'b1, {(RES-1){1'b0}}}));

  // R6: comparator clear is followed by a sample phase
  a_r6_clear_then_sample: assert property (@(posedge clk) disable iff (rst)
    compReset |=> (sampleHold && !compReset));

  // R7: result holds outside the done cycle
  a_r7_result_stable: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(resultCode));

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (sampleHold && dacSwitch == '0 && resultCode == '0 && !done));
endmodule

bind sar_seq_top sar_seq_checker u_checker (
  .clk        (clk),
  .rst        (rst),
  .sampleHold (sampleHold),
  .compReset  (compReset),
  .dacSwitch  (dacSwitch),
  .resultCode (resultCode),
  .done       (done)
);

// File: tb/sar_seq_top_bench.sv
module sar_seq_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] level = '0;
  logic       compIn;
  logic       sampleHold, compReset, done;
  logic [5:0] dacSwitch, resultCode;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lastDone = -1;
  bit finished = 1'b0;

  localparam int NVEC = 12;
  localparam logic [5:0] VECS [NVEC] = '{6'd0, 6'd63, 6'd32, 6'd31, 6'd1, 6'd62,
                                         6'd21, 6'd42, 6'd7, 6'd56, 6'd15, 6'd48};

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ideal comparator: high when the held level is at or above the DAC code
  assign compIn = (level >= dacSwitch);

  sar_seq_top u_sar_seq_top (
    .clk(clk), .rst(rst), .compIn(compIn), .sampleHold(sampleHold),
    .compReset(compReset), .dacSwitch(dacSwitch), .resultCode(resultCode), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runConv(input logic [5:0] v);
    int guard = 0;
    while (!sampleHold && guard < 20) begin @(negedge clk); guard++; end
    check("R5 sampleHold", sampleHold, 1);
    check("R5 dac zero in sample", dacSwitch, 0);
    level = v;
    @(negedge clk);
    check("R3 msb trial", dacSwitch, 32);
    check("R5 sampleHold low in bit phase", sampleHold, 0);
    @(negedge clk);
    check("R3 second trial", dacSwitch, {v[5], 5'b10000});
    guard = 0;
    while (!done && guard < 20) begin @(negedge clk); guard++; end
    check("R8 R4 result code", resultCode, v);
    check("R6 compReset with done", compReset, 1);
    if (lastDone >= 0) check("R2 done spacing", cyc - lastDone, 8);
    lastDone = cyc;
    @(negedge clk);
    check("R2 sample after reset phase", sampleHold, 1);
    check("R6 compReset one cycle", compReset, 0);
    check("R7 result held", resultCode, v);
    check("R7 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sampleHold", sampleHold, 1);
    check("R1 dac", dacSwitch, 0);
    check("R1 result", resultCode, 0);
    check("R1 done", done, 0);
    check("R1 compReset", compReset, 0);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) runConv(VECS[i]);

    // R9: reset in the middle of a conversion
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 back to sample", sampleHold, 1);
    check("R9 dac cleared", dacSwitch, 0);
    check("R9 result cleared", resultCode, 0);
    rst = 1'b0;
    lastDone = -1;
    runConv(6'd45);
    runConv(6'd18);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule